// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides a single fast input clock by a programmable integer N and emits a one-cycle pulse once every N input cycles. It is the feedback divider of a frequency synthesizer loop. A prescaler either divides by a fixed value P or alternates between P and P+1. A main counter counts B prescaler periods. A swallow counter selects the P+1 modulus for the first A of those periods. The result is N = P*B + A in dual-modulus mode and N = P*B in fixed mode. A bypass flag treats B as 1, so N reduces to P.

The working configuration is copied from the inputs only when a period ends, while any reset is applied, or while an illegal setting is held. A period that is already running therefore always completes with the settings it began with. Two level-held reset inputs and a sync input, which is gated by an enable, restart the count. An illegal setting raises an error flag and silences the output.

Top module: `pulse_swallow_div`

## Requirements
- R1: With `dm_mode`=1 the output period is P*B+A input cycles. The prescaler uses modulus P+1 for the first A prescaler periods of each output period and P for the rest.
- R2: With `dm_mode`=0 the output period is P*B input cycles, and the value on `a_cnt` has no effect.
- R3: `psel` codes 0..6 select P = 1, 2, 3, 4, 8, 16, 32. Code 7 is illegal in both modes. In dual-modulus mode only codes 1, 3, 4, 5 and 6 are legal, giving the pairs 2/3, 4/5, 8/9, 16/17 and 32/33.
- R4: A B value below 3 with `b_bypass`=0 is illegal.
- R5: In dual-modulus mode without bypass, A >= B is illegal.
- R6: With `b_bypass`=1 the period equals P in either mode (P=1 gives a pulse on every cycle). A nonzero A with bypass is illegal.
- R7: A = 0 swallows no cycles. It is never read as a maximum count.
- R8: While `ab_rst` or `grp_rst` is high, no pulse is produced. The first pulse comes N cycles after the last clock edge that sampled the reset high.
- R9: `sync_in` restarts the count only while `sync_en` is high. A sync reset in the same cycle as a terminal count wins: that pulse is suppressed and the next one follows N cycles later.
- R10: An illegal setting captured by the divider sets `cfg_err` and holds `div_out` low. A legal setting is taken on the next edge, `cfg_err` clears, and the first pulse follows N cycles after that edge.
- R11: Changes to mode, P, A, B or bypass take effect only at the end of the current period, so that period keeps its old length.
- R12: Each pulse is one input cycle wide. Different settings with equal N (fixed P=2,B=6; dual 2/3 with A=0,B=6; dual 4/5 with A=0,B=3) give identical periods of 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| dm_mode | input | 1 | 1 = dual-modulus prescaler, 0 = fixed divide |
| psel | input | 3 | Prescaler select code |
| a_cnt | input | AW | Swallow count A |
| b_cnt | input | BW | Main count B |
| b_bypass | input | 1 | Treat B as 1 |
| ab_rst | input | 1 | Level-held counter reset |
| grp_rst | input | 1 | Level-held shared divider reset |
| sync_in | input | 1 | External sync reset request |
| sync_en | input | 1 | Enables the sync reset path |
| div_out | output | 1 | Divided output pulse |
| cfg_err | output | 1 | Captured configuration is illegal |

## Verification
Two events can fall in the same cycle: a sync reset and a terminal count, and a configuration change and a terminal count. To provoke the first, the bench waits for a pulse, counts N-1 cycles so that the next edge is a terminal count, and raises the sync input for that single edge. It then expects no pulse on that edge and a fresh full period of N after it. For the second, the bench changes the settings partway through a period. It judges the result by two periods: the running period must keep the old N, and the period after it must show the new N.

// File: rtl/pswl_pkg.sv
package pswl_pkg;

  // prescaler modulus for a select code; 0 marks an unused code
  function automatic int unsigned pre_div(input logic [2:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 3;
      3'd3: return 4;
      3'd4: return 8;
      3'd5: return 16;
      3'd6: return 32;
      default: return 0;
    endcase
  endfunction

  // codes that have a P/P+1 pair
  function automatic logic dm_code_ok(input logic [2:0] code);
    return (code == 3'd1) || (code == 3'd3) || (code == 3'd4) ||
           (code == 3'd5) || (code == 3'd6);
  endfunction

  function automatic logic cfg_bad(input logic dm, input logic [2:0] code,
                                   input int unsigned a, input int unsigned b,
                                   input logic byp);
    logic bad;
    bad = (code == 3'd7);
    if (dm && !dm_code_ok(code)) bad = 1'b1;
    if (byp && a != 0) bad = 1'b1;
    if (!byp && b < 3) bad = 1'b1;
    if (dm && !byp && a >= b) bad = 1'b1;
    return bad;
  endfunction

endpackage

// File: rtl/pscl_mod.sv
module pscl_mod #(
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [PW-1:0] p_val,
  input  logic          swal,
  output logic          tick
);
  logic [PW-1:0] pc;
  logic [PW-1:0] modv;

  assign modv = swal ? p_val + PW'(1) : p_val;
  assign tick = run && (pc == modv - PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc <= '0;
    else if (clr)    pc <= '0;
    else if (tick)   pc <= '0;
    else if (run)    pc <= pc + PW'(1);
  end

  // prescaler period never runs past its modulus
  p_pc_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr) |-> (pc < modv));

endmodule

// File: rtl/ab_cnt.sv
module ab_cnt #(
  parameter int AW = 6,
  parameter int BW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [AW-1:0] a_val,
  input  logic [BW-1:0] b_val,
  output logic          swal,
  output logic          tc
);
  logic [AW-1:0] sw;
  logic [BW-1:0] bc;

  assign swal = (sw < a_val);
  assign tc   = tick && (bc == b_val - BW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw <= '0;
      bc <= '0;
    end else if (clr) begin
      sw <= '0;
      bc <= '0;
    end else if (tick) begin
      bc <= bc + BW'(1);
      if (swal) sw <= sw + AW'(1);
    end
  end

  // swallow count never exceeds A (A = 0 swallows nothing)
  p_swallow_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (sw <= a_val));
  // main count stays inside B
  p_bc_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (bc < b_val));

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import pswl_pkg::*;
#(
  parameter int AW = 6,
  parameter int BW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dm_mode,
  input  logic [2:0]    psel,
  input  logic [AW-1:0] a_cnt,
  input  logic [BW-1:0] b_cnt,
  input  logic          b_bypass,
  input  logic          ab_rst,
  input  logic          grp_rst,
  input  logic          sync_in,
  input  logic          sync_en,
  output logic          div_out,
  output logic          cfg_err
);
  localparam int PW = $clog2(32 + 2);

  logic          act_dm;
  logic [PW-1:0] act_p;
  logic [AW-1:0] act_a;
  logic [BW-1:0] act_b;
  logic          err_q;
  logic          out_q;

  logic reload_rst;
  logic reload;
  logic in_bad;
  logic tick;
  logic swal;
  logic tc;

  assign reload_rst = ab_rst | grp_rst | (sync_en & sync_in);
  assign reload     = reload_rst | err_q | tc;
  assign in_bad     = cfg_bad(dm_mode, psel, 32'(a_cnt), 32'(b_cnt), b_bypass);

  // shadow configuration, captured only on reload
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_dm <= 1'b0;
      act_p  <= PW'(1);
      act_a  <= '0;
      act_b  <= BW'(1);
      err_q  <= 1'b0;
    end else if (reload) begin
      act_dm <= dm_mode;
      act_p  <= PW'(pre_div(psel));
      act_a  <= (dm_mode && !b_bypass) ? a_cnt : '0;
      act_b  <= b_bypass ? BW'(1) : b_cnt;
      err_q  <= in_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= tc && !reload_rst;
  end

  pscl_mod #(.PW(PW)) u_pscl (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (reload),
    .run   (!err_q),
    .p_val (act_p),
    .swal  (swal),
    .tick  (tick)
  );

  ab_cnt #(.AW(AW), .BW(BW)) u_ab (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (reload),
    .tick  (tick),
    .a_val (act_a),
    .b_val (act_b),
    .swal  (swal),
    .tc    (tc)
  );

  assign div_out = out_q;
  assign cfg_err = err_q;

  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && $past(err_q)) |-> !div_out);
  p_rst_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reload_rst |=> !div_out);
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> ($stable(act_p) && $stable(act_a) && $stable(act_b) && $stable(act_dm)));
  p_width_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (div_out && !(act_p == PW'(1) && act_b == BW'(1))) |=> !div_out);
  p_fd_noswal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_dm && !reload) |-> !swal);

endmodule

// File: tb/pulse_swallow_div_tb_top.sv
`timescale 1ns/1ps
module pulse_swallow_div_tb_top;
  localparam int AW = 6;
  localparam int BW = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dm_mode = 1'b0;
  logic [2:0]    psel = 3'd0;
  logic [AW-1:0] a_cnt = '0;
  logic [BW-1:0] b_cnt = '0;
  logic          b_bypass = 1'b0;
  logic          ab_rst = 1'b0;
  logic          grp_rst = 1'b0;
  logic          sync_in = 1'b0;
  logic          sync_en = 1'b0;
  logic          div_out;
  logic          cfg_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  pulse_swallow_div #(.AW(AW), .BW(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .dm_mode(dm_mode), .psel(psel),
    .a_cnt(a_cnt), .b_cnt(b_cnt), .b_bypass(b_bypass),
    .ab_rst(ab_rst), .grp_rst(grp_rst), .sync_in(sync_in), .sync_en(sync_en),
    .div_out(div_out), .cfg_err(cfg_err)
  );

  // independent statement of the period; 0 means illegal
  function automatic int n_ref(bit dm, int c, int a, int b, bit byp);
    int p;
    if (c == 7) return 0;
    p = (c < 4) ? c + 1 : (1 << (c - 1));
    if (dm && (c == 0 || c == 2)) return 0;
    if (byp) return (a == 0) ? p : 0;
    if (b < 3) return 0;
    if (dm) return (a >= b) ? 0 : p * b + a;
    return p * b;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(bit dm, int c, int a, int b, bit byp);
    dm_mode = dm; psel = 3'(c); a_cnt = AW'(a); b_cnt = BW'(b); b_bypass = byp;
  endtask

  task automatic wait_pulse(string tag);
    int k = 0;
    do begin @(negedge clk); k++; end while (!div_out && k < 6000);
    if (!div_out) check(0, {tag, " no pulse"}, 0, 1);
  endtask

  // from a negedge, count negedges until div_out is seen high
  task automatic count_to_pulse(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!div_out && k < 6000);
  endtask

  task automatic measure(int exp, string tag);
    int k;
    wait_pulse(tag);
    count_to_pulse(k);
    check(k == exp, tag, k, exp);
  endtask

  // config change: boundary, then a clean period
  task automatic run_cfg(bit dm, int c, int a, int b, bit byp, string tag);
    int exp;
    exp = n_ref(dm, c, a, b, byp);
    set_cfg(dm, c, a, b, byp);
    wait_pulse(tag);
    measure(exp, tag);
  endtask

  task automatic t_reset;
    check(div_out == 0, "R8 reset div_out", int'(div_out), 0);
    check(cfg_err == 0, "R10 reset cfg_err", int'(cfg_err), 0);
  endtask

  task automatic t_dual;
    run_cfg(1, 1, 2, 3, 0, "R1 dm 2/3 A2 B3");
    run_cfg(1, 4, 7, 18, 0, "R1 dm 8/9 A7 B18");
    run_cfg(1, 6, 22, 84, 0, "R1 dm 32/33 A22 B84");
    run_cfg(1, 5, 0, 5, 0, "R7 dm 16/17 A0 B5");
  endtask

  task automatic t_fixed;
    run_cfg(0, 2, 5, 4, 0, "R2 fd P3 B4 A ignored");
    run_cfg(0, 5, 63, 9, 0, "R3 fd P16 B9");
    run_cfg(0, 4, 0, 3, 0, "R3 fd P8 B3");
  endtask

  task automatic t_width;
    int k;
    set_cfg(1, 3, 1, 4, 0);
    wait_pulse("R12 width");
    wait_pulse("R12 width");
    @(negedge clk);
    check(div_out == 0, "R12 one-cycle pulse", int'(div_out), 0);
  endtask

  task automatic t_equiv;
    run_cfg(0, 1, 0, 6, 0, "R12 equiv fd P2 B6");
    run_cfg(1, 1, 0, 6, 0, "R12 equiv dm 2/3 A0 B6");
    run_cfg(1, 3, 0, 3, 0, "R12 equiv dm 4/5 A0 B3");
  endtask

  task automatic t_bypass;
    run_cfg(0, 6, 0, 0, 1, "R6 bypass fd P32");
    run_cfg(1, 3, 0, 7, 1, "R6 bypass dm P4");
    run_cfg(0, 0, 0, 0, 1, "R6 bypass P1 every cycle");
    set_cfg(0, 0, 0, 0, 1);
    @(negedge clk);
    check(div_out == 1, "R6 P1 stays high", int'(div_out), 1);
  endtask

  task automatic t_illegal(bit dm, int c, int a, int b, bit byp, string tag);
    int k;
    bit quiet;
    set_cfg(dm, c, a, b, byp);
    wait_pulse(tag);
    check(cfg_err == 1, {tag, " cfg_err set"}, int'(cfg_err), 1);
    quiet = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (div_out) quiet = 0;
    end
    check(quiet, {tag, " output held low"}, int'(!quiet), 0);
    set_cfg(1, 1, 2, 3, 0);
    @(negedge clk);
    check(cfg_err == 0, "R10 cfg_err cleared", int'(cfg_err), 0);
    count_to_pulse(k);
    check(k == 8, "R10 first pulse after recovery", k, 8);
  endtask

  task automatic t_midchange;
    int k;
    set_cfg(1, 1, 2, 3, 0);
    wait_pulse("R11");
    wait_pulse("R11");
    k = 0;
    repeat (3) begin @(negedge clk); k++; end
    set_cfg(0, 3, 0, 5, 0);
    do begin @(negedge clk); k++; end while (!div_out && k < 6000);
    check(k == 8, "R11 running period kept", k, 8);
    count_to_pulse(k);
    check(k == 20, "R11 new period applied", k, 20);
  endtask

  task automatic t_held(bit use_grp, string tag);
    int k;
    bit quiet;
    set_cfg(0, 3, 0, 5, 0);
    wait_pulse(tag);
    @(negedge clk);
    if (use_grp) grp_rst = 1; else ab_rst = 1;
    quiet = 1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (div_out) quiet = 0;
    end
    check(quiet, {tag, " no pulse while held"}, int'(!quiet), 0);
    grp_rst = 0; ab_rst = 0;
    count_to_pulse(k);
    check(k == 20, {tag, " first pulse after release"}, k, 20);
  endtask

  task automatic t_sync;
    int k;
    set_cfg(1, 1, 1, 4, 0);
    wait_pulse("R9");
    wait_pulse("R9");
    k = 0;
    repeat (3) begin @(negedge clk); k++; end
    sync_en = 0; sync_in = 1;
    @(negedge clk); k++;
    sync_in = 0;
    do begin @(negedge clk); k++; end while (!div_out && k < 6000);
    check(k == 9, "R9 gated sync ignored", k, 9);
    repeat (8) @(negedge clk);
    sync_en = 1; sync_in = 1;
    @(negedge clk);
    sync_in = 0;
    check(div_out == 0, "R9 sync beats terminal count", int'(div_out), 0);
    count_to_pulse(k);
    check(k == 9, "R9 full period after sync", k, 9);
    sync_en = 0;
  endtask

  initial begin
    set_cfg(1, 1, 2, 3, 0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_dual();
    t_fixed();
    t_width();
    t_equiv();
    t_bypass();
    set_cfg(1, 1, 2, 3, 0);
    wait_pulse("restore");
    t_illegal(0, 1, 0, 2, 0, "R4 B2 no bypass");
    t_illegal(1, 3, 3, 3, 0, "R5 A equals B");
    t_illegal(1, 0, 0, 5, 0, "R3 dm code0");
    t_illegal(0, 7, 0, 5, 0, "R3 code7");
    t_illegal(0, 2, 3, 0, 1, "R6 bypass with A");
    t_midchange();
    t_held(0, "R8 ab_rst");
    t_held(1, "R8 grp_rst");
    t_sync();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule